// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out maintenance commands on the tag and data storage of a two-way, 64-set data cache with 64-byte lines. A command has three parts: a 5-bit code, a 32-bit address and a 32-bit register value. The block accepts one command at a time. It reads and writes the storage through a shared set/way port. When a line must be flushed, it pushes the line out through a 64-bit memory write port. When the command is finished it raises `done` for one cycle, and any value it has loaded appears on `reg_out`.

There are two kinds of command. Lookup commands compare the address page against both ways of the addressed set and act on the way that hits. Direct commands take the way from address bit 0 and need no match. Each tag word holds the page in bits [31:12], dirty in bit 6, valid in bit 5 and the replacement flag in bit 4. The storage is read combinationally: `tag_rdata` and `dat_rdata` reflect `arr_set`, `arr_way` and `dat_beat` in the same cycle. Writes to the storage take effect at the clock edge.

Top module: `cache_maint_seq`

## Requirements
- R1: `busy` rises in the cycle after a command is taken while idle and stays high until the cycle after `done`. Any command offered while `busy` is high is dropped and changes no state.
- R2: Code 0x1A (lookup invalidate) acts on a hit. It clears the hit tag to the replacement flag alone (tag AND 0x10) and writes zero to all 64 bytes of that line, with no memory traffic.
- R3: Code 0x18 (lookup flush-and-invalidate) acts on a hit. It first sends the line to memory if the tag has both dirty and valid set, and then invalidates the line as in R2.
- R4: Code 0x1C (lookup flush-and-keep) acts on a hit. A line that is both dirty and valid is sent to memory, and only its dirty bit is cleared. A clean hit changes nothing.
- R5: A lookup hits a way whose tag is valid and whose page equals address bits [31:12]. Way 0 wins when both ways match. A miss, which includes a matching page with valid clear, leaves the storage untouched and sends nothing to memory.
- R6: Direct commands use address bits [11:6] as the set and bit 0 as the way. Code 0x16 invalidates that line as in R2, whatever its tag holds.
- R7: Code 0x14 sends the selected line to address {tag[31:12], addr[11:6], 6'b0} when the tag is dirty and valid, and then invalidates the line as in R2.
- R8: Code 0x10 loads the selected tag word into `reg_out`. Code 0x12 writes `cmd_reg` into the selected tag word.
- R9: Code 0x11 loads one 32-bit data word into `reg_out`, and code 0x13 writes `cmd_reg` into that word. Address bits [5:3] pick the 64-bit beat and bit 2 picks the upper (1) or lower (0) half of it.
- R10: Codes 0x07 and 0x0C, and every code not listed above, finish with `done` and leave the storage, `reg_out` and memory port unchanged.
- R11: A flush sends eight beats on the memory port at ascending addresses, 8 bytes apart, starting at the line base. Beat n carries bytes 8n to 8n+7 of the line. Address and data hold steady while `mem_ready` is low. `done` comes after the last beat is taken.
- R12: `done` is a single-cycle pulse. `reg_out` keeps its value except when a load code completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 5 | Maintenance code |
| cmd_addr | input | 32 | Command address |
| cmd_reg | input | 32 | Register value for store codes |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| reg_out | output | 32 | Loaded register value |
| arr_set | output | 6 | Set for storage access |
| arr_way | output | 1 | Way for storage access and writes |
| tag_rdata | input | 64 | Tags of both ways of `arr_set` (way 0 in the low word) |
| tag_we | output | 1 | Tag write strobe |
| tag_wdata | output | 32 | Tag write value |
| dat_beat | output | 3 | 64-bit beat within the line |
| dat_rdata | input | 64 | Beat read from `arr_set`/`arr_way`/`dat_beat` |
| dat_we | output | 1 | Data write strobe |
| dat_be | output | 8 | Byte enables for data write |
| dat_wdata | output | 64 | Data write value |
| mem_valid | output | 1 | Flush beat valid |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | 32 | Flush beat address |
| mem_data | output | 64 | Flush beat data |

## Verification
The assertions take for granted that nothing except this block writes the cache storage while a command runs. From this it follows that `mem_data` holds steady during a stalled beat. They also take for granted that both storage reads are combinational for the current set, way and beat. The bench keeps to these conditions: it holds the storage in its own arrays, which only this block's write strobes change, and it answers reads in the same cycle. It stalls `mem_ready` one cycle in three, so every flush meets back-pressure. A reference model compares every beat as it is taken, and compares the whole storage after each command.

// File: rtl/cms_pkg.sv
package cms_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVAL,
      ST_WB,
      ST_CLR,
      ST_FIN
   } cms_state_e;

   localparam logic [4:0] OP_HIT_INV   = 5'h1A;
   localparam logic [4:0] OP_HIT_WBINV = 5'h18;
   localparam logic [4:0] OP_HIT_WB    = 5'h1C;
   localparam logic [4:0] OP_IDX_INV   = 5'h16;
   localparam logic [4:0] OP_IDX_WBINV = 5'h14;
   localparam logic [4:0] OP_LD_TAG    = 5'h10;
   localparam logic [4:0] OP_ST_TAG    = 5'h12;
   localparam logic [4:0] OP_LD_WORD   = 5'h11;
   localparam logic [4:0] OP_ST_WORD   = 5'h13;

   localparam int FLAG_DIRTY = 6;
   localparam int FLAG_VALID = 5;
   localparam int FLAG_REPL  = 4;
   localparam int WORD_W     = 32;
endpackage

// File: rtl/cms_lookup.sv
module cms_lookup #(
   parameter int ADDR_W  = 32,
   parameter int WAYS    = 2,
   parameter int PAGE_LO = 12
) (
   input  logic [WAYS*ADDR_W-1:0]      tags,
   input  logic [ADDR_W-1:PAGE_LO]     page,
   output logic                        hit,
   output logic [$clog2(WAYS)-1:0]     hit_way
);
   import cms_pkg::*;
   localparam int WAY_W = $clog2(WAYS);

   initial begin
      assert (WAYS >= 2 && (1 << WAY_W) == WAYS)
         else $error("cms_lookup: WAYS must be a power of two >= 2");
      assert (PAGE_LO > FLAG_DIRTY && PAGE_LO < ADDR_W)
         else $error("cms_lookup: page field overlaps flags");
   end

   logic [WAYS-1:0] match;
   logic            unused_tags;
   assign unused_tags = ^tags;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign match[g] = tags[g*ADDR_W + FLAG_VALID] &&
                        (tags[g*ADDR_W + PAGE_LO +: ADDR_W-PAGE_LO] == page);
   end

   // lowest-numbered way wins when several match
   always_comb begin
      hit     = |match;
      hit_way = '0;
      for (int k = WAYS-1; k >= 0; k--) begin
         if (match[k]) hit_way = WAY_W'(k);
      end
   end
endmodule

// File: rtl/cms_lane.sv
module cms_lane #(
   parameter int BEAT_W = 64,
   parameter int WORD_W = 32
) (
   input  logic [$clog2(BEAT_W/WORD_W)-1:0] lane_sel,
   input  logic [BEAT_W-1:0]                rdata,
   input  logic [WORD_W-1:0]                wword,
   output logic [WORD_W-1:0]                rword,
   output logic [BEAT_W-1:0]                wbeat,
   output logic [BEAT_W/8-1:0]              be
);
   localparam int LANES  = BEAT_W / WORD_W;
   localparam int LANE_W = $clog2(LANES);
   localparam int WBYTES = WORD_W / 8;

   initial begin
      assert (LANES >= 2 && LANES * WORD_W == BEAT_W && WORD_W % 8 == 0)
         else $error("cms_lane: beat must hold two or more whole words");
   end

   assign rword = rdata[lane_sel*WORD_W +: WORD_W];
   assign wbeat = {LANES{wword}};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign be[l*WBYTES +: WBYTES] = {WBYTES{lane_sel == LANE_W'(l)}};
   end
endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
   parameter int ADDR_W     = 32,
   parameter int WAYS       = 2,
   parameter int SETS       = 64,
   parameter int LINE_BYTES = 64,
   parameter int BEAT_W     = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmd_valid,
   input  logic [4:0]                    cmd_op,
   input  logic [ADDR_W-1:0]             cmd_addr,
   input  logic [31:0]                   cmd_reg,
   output logic                          busy,
   output logic                          done,
   output logic [31:0]                   reg_out,
   output logic [$clog2(SETS)-1:0]       arr_set,
   output logic [$clog2(WAYS)-1:0]       arr_way,
   input  logic [WAYS*ADDR_W-1:0]        tag_rdata,
   output logic                          tag_we,
   output logic [ADDR_W-1:0]             tag_wdata,
   output logic [$clog2(LINE_BYTES*8/BEAT_W)-1:0] dat_beat,
   input  logic [BEAT_W-1:0]             dat_rdata,
   output logic                          dat_we,
   output logic [BEAT_W/8-1:0]           dat_be,
   output logic [BEAT_W-1:0]             dat_wdata,
   output logic                          mem_valid,
   input  logic                          mem_ready,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [BEAT_W-1:0]             mem_data
);
   import cms_pkg::*;

   localparam int SET_W      = $clog2(SETS);
   localparam int WAY_W      = $clog2(WAYS);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int PAGE_LO    = SET_W + OFF_W;
   localparam int BEAT_BYTES = BEAT_W / 8;
   localparam int BOFF_W     = $clog2(BEAT_BYTES);
   localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
   localparam int BEAT_IW    = $clog2(BEATS);
   localparam int LANE_W     = $clog2(BEAT_W / WORD_W);
   localparam int LINE_AW    = ADDR_W - OFF_W;

   initial begin
      assert (ADDR_W == WORD_W) else $error("cache_maint_seq: tag word must be 32 bits");
      assert ((1 << SET_W) == SETS) else $error("cache_maint_seq: SETS not a power of two");
      assert ((1 << OFF_W) == LINE_BYTES && BEATS >= 2)
         else $error("cache_maint_seq: line must hold two or more beats");
      assert (BEAT_W >= 2*WORD_W) else $error("cache_maint_seq: beat narrower than two words");
   end

   cms_state_e              st;
   logic [4:0]              op_q;
   logic [ADDR_W-1:0]       addr_q;
   logic [31:0]             reg_q;
   logic [31:0]             out_q;
   logic [WAY_W-1:0]        way_q;
   logic [BEAT_IW-1:0]      beat_q;
   logic [LINE_AW-1:0]      line_q;

   logic                    hit;
   logic [WAY_W-1:0]        hit_way;
   logic                    is_hit_op;
   logic [ADDR_W-1:0]       sel_tag;
   logic                    dv;
   logic [LINE_AW-1:0]      wb_line;
   logic [WORD_W-1:0]       rword;
   logic [BEAT_W-1:0]       wbeat;
   logic [BEAT_W/8-1:0]     word_be;
   logic                    last_beat;
   logic                    unused_addr;

   assign unused_addr = ^addr_q;

   cms_lookup #(.ADDR_W(ADDR_W), .WAYS(WAYS), .PAGE_LO(PAGE_LO)) i_lookup (
      .tags    (tag_rdata),
      .page    (addr_q[ADDR_W-1:PAGE_LO]),
      .hit     (hit),
      .hit_way (hit_way)
   );

   cms_lane #(.BEAT_W(BEAT_W), .WORD_W(WORD_W)) i_lane (
      .lane_sel (addr_q[BOFF_W-1:BOFF_W-LANE_W]),
      .rdata    (dat_rdata),
      .wword    (reg_q),
      .rword    (rword),
      .wbeat    (wbeat),
      .be       (word_be)
   );

   assign is_hit_op = (op_q == OP_HIT_INV) || (op_q == OP_HIT_WBINV) || (op_q == OP_HIT_WB);
   assign arr_set   = addr_q[PAGE_LO-1:OFF_W];
   assign arr_way   = (st == ST_EVAL) ? (is_hit_op ? hit_way : addr_q[WAY_W-1:0]) : way_q;
   assign dat_beat  = (st == ST_EVAL) ? addr_q[OFF_W-1:BOFF_W] : beat_q;
   assign sel_tag   = tag_rdata[arr_way*ADDR_W +: ADDR_W];
   assign dv        = sel_tag[FLAG_DIRTY] && sel_tag[FLAG_VALID];
   assign wb_line   = is_hit_op ? addr_q[ADDR_W-1:OFF_W]
                                : {sel_tag[ADDR_W-1:PAGE_LO], arr_set};
   assign last_beat = (beat_q == BEAT_IW'(BEATS-1));

   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FIN);
   assign reg_out   = out_q;
   assign mem_valid = (st == ST_WB);
   assign mem_addr  = {line_q, beat_q, BOFF_W'(0)};
   assign mem_data  = dat_rdata;

   // storage write strobes
   always_comb begin
      tag_we    = 1'b0;
      tag_wdata = sel_tag;
      dat_we    = 1'b0;
      dat_be    = '1;
      dat_wdata = '0;
      unique case (st)
         ST_EVAL: begin
            if (op_q == OP_ST_TAG) begin
               tag_we    = 1'b1;
               tag_wdata = reg_q;
            end
            if (op_q == OP_ST_WORD) begin
               dat_we    = 1'b1;
               dat_be    = word_be;
               dat_wdata = wbeat;
            end
         end
         ST_WB: begin
            if (mem_ready && last_beat && op_q == OP_HIT_WB) begin
               tag_we    = 1'b1;
               tag_wdata = sel_tag & ~(ADDR_W'(1) << FLAG_DIRTY);
            end
         end
         ST_CLR: begin
            dat_we = 1'b1;
            if (beat_q == '0) begin
               tag_we    = 1'b1;
               tag_wdata = sel_tag & (ADDR_W'(1) << FLAG_REPL);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= '0;
         addr_q <= '0;
         reg_q  <= '0;
         out_q  <= '0;
         way_q  <= '0;
         beat_q <= '0;
         line_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q   <= cmd_op;
                  addr_q <= cmd_addr;
                  reg_q  <= cmd_reg;
                  st     <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               way_q  <= arr_way;
               beat_q <= '0;
               line_q <= wb_line;
               unique case (op_q)
                  OP_HIT_INV:   st <= hit ? ST_CLR : ST_FIN;
                  OP_HIT_WBINV: st <= !hit ? ST_FIN : (dv ? ST_WB : ST_CLR);
                  OP_HIT_WB:    st <= (hit && dv) ? ST_WB : ST_FIN;
                  OP_IDX_INV:   st <= ST_CLR;
                  OP_IDX_WBINV: st <= dv ? ST_WB : ST_CLR;
                  OP_LD_TAG: begin
                     out_q <= sel_tag;
                     st    <= ST_FIN;
                  end
                  OP_LD_WORD: begin
                     out_q <= rword;
                     st    <= ST_FIN;
                  end
                  default:      st <= ST_FIN;
               endcase
            end
            ST_WB: begin
               if (mem_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) st <= (op_q == OP_HIT_WB) ? ST_FIN : ST_CLR;
               end
            end
            ST_CLR: begin
               beat_q <= beat_q + 1'b1;
               if (last_beat) st <= ST_FIN;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R1
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy);
   // R1
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && cmd_valid |=> busy);
   // R11
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
   // R11
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)));
   // R11
   beat_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_valid) |-> mem_addr[OFF_W-1:0] == '0);
   // R11
   beat_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> busy && !done);
   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
endmodule

// File: tb/test_cache_maint_seq.sv
`timescale 1ns/1ps
module test_cache_maint_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [4:0]  cmd_op = '0;
   logic [31:0] cmd_addr = '0;
   logic [31:0] cmd_reg = '0;
   logic        busy, done;
   logic [31:0] reg_out;
   logic [5:0]  arr_set;
   logic        arr_way;
   logic [63:0] tag_rdata;
   logic        tag_we;
   logic [31:0] tag_wdata;
   logic [2:0]  dat_beat;
   logic [63:0] dat_rdata;
   logic        dat_we;
   logic [7:0]  dat_be;
   logic [63:0] dat_wdata;
   logic        mem_valid, mem_ready;
   logic [31:0] mem_addr;
   logic [63:0] mem_data;

   always #4 clk = ~clk;

   cache_maint_seq i_cache_maint_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .busy(busy), .done(done),
      .reg_out(reg_out), .arr_set(arr_set), .arr_way(arr_way),
      .tag_rdata(tag_rdata), .tag_we(tag_we), .tag_wdata(tag_wdata),
      .dat_beat(dat_beat), .dat_rdata(dat_rdata), .dat_we(dat_we),
      .dat_be(dat_be), .dat_wdata(dat_wdata), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   // cache storage, written only by the block
   logic [31:0] tg [2][64];
   logic [63:0] dt [2][64][8];
   // reference model state
   logic [31:0] stg [2][64];
   logic [63:0] sdt [2][64][8];
   logic [95:0] expq [$];
   logic [31:0] exp_reg = '0;

   int errors = 0;
   int checks = 0;
   int rdy_cnt = 0;

   function automatic logic [63:0] pat(int w, int s, int b);
      return {8'(w + 1), 8'(s), 8'(b), 8'h3C, 32'h9E37_79B9 ^ 32'(s*97 + b*13 + w)};
   endfunction

   function automatic logic [31:0] mk(logic [19:0] page, int set, logic [5:0] off);
      return {page, 6'(set), off};
   endfunction

   assign tag_rdata = {tg[1][arr_set], tg[0][arr_set]};
   assign dat_rdata = dt[arr_way][arr_set][dat_beat];
   assign mem_ready = (rdy_cnt % 3) != 2;

   always @(posedge clk) begin
      rdy_cnt <= rdy_cnt + 1;
      if (!rst_n) begin
         for (int w = 0; w < 2; w++)
            for (int s = 0; s < 64; s++) begin
               tg[w][s] <= '0;
               for (int b = 0; b < 8; b++) dt[w][s][b] <= pat(w, s, b);
            end
      end else begin
         if (tag_we) tg[arr_way][arr_set] <= tag_wdata;
         if (dat_we)
            for (int b = 0; b < 8; b++)
               if (dat_be[b]) dt[arr_way][arr_set][dat_beat][b*8 +: 8] <= dat_wdata[b*8 +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic kill_line(input int w, input int s);
      stg[w][s] = stg[w][s] & 32'h10;
      for (int b = 0; b < 8; b++) sdt[w][s][b] = '0;
   endtask

   task automatic push_line(input int w, input int s, input logic [25:0] line);
      for (int b = 0; b < 8; b++) expq.push_back({line, 3'(b), 3'b000, sdt[w][s][b]});
   endtask

   // reference model: applies one command to the shadow state
   task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] rv);
      int s, w, hw;
      bit hit, dirtyv;
      s = int'(a[11:6]);
      w = int'(a[0]);
      hit = 1'b0;
      hw = 0;
      for (int k = 1; k >= 0; k--)
         if (stg[k][s][5] && stg[k][s][31:12] == a[31:12]) begin hit = 1'b1; hw = k; end
      case (op)
         5'h1A, 5'h18, 5'h1C: if (hit) begin
            dirtyv = stg[hw][s][6] && stg[hw][s][5];
            if (op != 5'h1A && dirtyv) push_line(hw, s, a[31:6]);
            if (op == 5'h1C) begin
               if (dirtyv) stg[hw][s][6] = 1'b0;
            end else kill_line(hw, s);
         end
         5'h16: kill_line(w, s);
         5'h14: begin
            if (stg[w][s][6] && stg[w][s][5]) push_line(w, s, {stg[w][s][31:12], 6'(s)});
            kill_line(w, s);
         end
         5'h10: exp_reg = stg[w][s];
         5'h12: stg[w][s] = rv;
         5'h11: exp_reg = a[2] ? sdt[w][s][a[5:3]][63:32] : sdt[w][s][a[5:3]][31:0];
         5'h13: if (a[2]) sdt[w][s][a[5:3]][63:32] = rv; else sdt[w][s][a[5:3]][31:0] = rv;
         default: ;
      endcase
   endtask

   task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] rv,
                      input string req, input bit interfere = 1'b0);
      bit seen;
      int n, bad;
      logic [95:0] e;
      model(op, a, rv);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_reg = rv;
      @(posedge clk);
      #1;
      if (interfere) begin
         cmd_op = 5'h12; cmd_reg = 32'hDEAD_BEEF;
      end else cmd_valid = 1'b0;
      seen = 1'b0;
      n = 0;
      while (!seen && n < 200) begin
         @(negedge clk);
         n++;
         chk(busy === 1'b1, "R1", "busy during command", 64'(busy), 64'd1);
         if (mem_valid && mem_ready) begin
            if (expq.size() == 0) chk(1'b0, "R11", "unexpected flush beat", {32'd0, mem_addr}, 64'd0);
            else begin
               e = expq.pop_front();
               chk(mem_addr == e[95:64], "R11", "beat address", 64'(mem_addr), 64'(e[95:64]));
               chk(mem_data == e[63:0], req, "beat data", mem_data, e[63:0]);
            end
         end
         if (done) seen = 1'b1;
      end
      cmd_valid = 1'b0;
      chk(seen, "R12", "done seen", 64'(seen), 64'd1);
      chk(reg_out == exp_reg, req, "reg_out", 64'(reg_out), 64'(exp_reg));
      chk(expq.size() == 0, "R11", "beats missing", 64'(expq.size()), 64'd0);
      expq.delete();
      @(negedge clk);
      chk(!done && !busy, "R12", "done/busy after pulse", {62'd0, done, busy}, 64'd0);
      bad = 0;
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 64; s++) begin
            if (tg[w][s] !== stg[w][s]) bad++;
            for (int b = 0; b < 8; b++) if (dt[w][s][b] !== sdt[w][s][b]) bad++;
         end
      chk(bad == 0, req, "storage mismatches", 64'(bad), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 64; s++) begin
            stg[w][s] = '0;
            for (int b = 0; b < 8; b++) sdt[w][s][b] = pat(w, s, b);
         end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !done && !mem_valid && reg_out == 0, "R12", "reset state",
          {busy, done, mem_valid, 29'd0, reg_out}, 64'd0);
      rst_n = 1'b1;

      run(5'h12, mk(0, 5, 6'h00), 32'hABCDE070, "R8");
      run(5'h12, mk(0, 5, 6'h01), 32'h12345030, "R8");
      run(5'h13, mk(0, 5, 6'h14), 32'h1111_2222, "R9");
      run(5'h13, mk(0, 5, 6'h38), 32'h3333_4444, "R9");
      run(5'h11, mk(0, 5, 6'h14), 32'h0, "R9");
      run(5'h11, mk(0, 5, 6'h21), 32'h0, "R9");
      run(5'h10, mk(0, 5, 6'h01), 32'h0, "R8");
      run(5'h1C, mk(20'hABCDE, 5, 6'h08), 32'h0, "R4");
      run(5'h1C, mk(20'hABCDE, 5, 6'h08), 32'h0, "R4");
      run(5'h1A, mk(20'h12345, 5, 6'h3C), 32'h0, "R2");
      run(5'h18, mk(20'h55555, 5, 6'h00), 32'h0, "R5");
      run(5'h12, mk(0, 5, 6'h00), 32'hABCDE060, "R8");
      run(5'h18, mk(20'hABCDE, 5, 6'h10), 32'h0, "R3");
      run(5'h12, mk(0, 9, 6'h01), 32'h0F0F0070, "R8");
      run(5'h14, mk(20'hFFFFF, 9, 6'h01), 32'h0, "R7");
      run(5'h16, mk(0, 9, 6'h00), 32'h0, "R6");
      run(5'h12, mk(0, 20, 6'h00), 32'h77777060, "R8");
      run(5'h12, mk(0, 20, 6'h01), 32'h77777070, "R8");
      run(5'h1C, mk(20'h77777, 20, 6'h00), 32'h0, "R5");
      run(5'h12, mk(0, 21, 6'h00), 32'h00000040, "R8");
      run(5'h1C, mk(0, 21, 6'h00), 32'h0, "R5");
      run(5'h14, mk(0, 21, 6'h00), 32'h0, "R7");
      run(5'h10, mk(0, 20, 6'h01), 32'h0, "R8");
      run(5'h07, mk(20'hABCDE, 5, 6'h00), 32'h0, "R10");
      run(5'h0C, mk(20'h77777, 20, 6'h01), 32'h0, "R10");
      run(5'h1F, mk(20'h77777, 20, 6'h00), 32'h0, "R10");
      run(5'h1B, mk(20'h77777, 20, 6'h00), 32'h0, "R10");
      run(5'h16, mk(0, 30, 6'h00), 32'h0, "R1", 1'b1);
      run(5'h12, mk(0, 31, 6'h00), 32'hCAFE0070, "R8");
      run(5'h18, mk(20'hCAFE0, 31, 6'h00), 32'h0, "R1", 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule